// File: doc/BRIEF.md
# Address Translation Buffer with Global Entries

This block is a small, fully associative buffer of cached page translations. A chip uses one instance for instruction fetches and a second for data accesses. In the same cycle that a request is presented, it looks up a 32-bit virtual address and returns a 36-bit physical address and the cachable attribute. It checks the access against the write, execute and user rights held in the cached page descriptor. When no entry matches, it raises a miss so that an external table walker can supply a refill.

Each entry maps either a 4 KB page or a 4 MB page. A context switch drops every entry that is not marked global. A separate invalidate command removes any entry that covers a given virtual address, global or not. Translation stays off until it is switched on through an enable write. While it is off, addresses pass straight through.

Top module: `xlat_tlb`

## Requirements
- R1: After reset (rst_ni low), and again after any later reset, translation is off and every entry is invalid.
- R2: A cycle with en_wr_i high loads en_val_i into the enable state. The new state governs lookups from the following cycle on.
- R3: While translation is off: hit_o, miss_o, fault_o and cachable_o are 0, fault_code_o is 0, and pa_o equals va_i zero-extended to 36 bits.
- R4: A 4 KB entry matches when its tag equals va_i[31:12]. In the same cycle, hit_o is 1, pa_o = {ppn, va_i[11:0]} and cachable_o is the entry's C bit.
- R5: A 4 MB entry (fill_big_i = 1) compares only va_i[31:22]. Its translation is pa_o = {ppn[23:10], va_i[21:0]}.
- R6: With translation on and req_i high, a lookup that matches no valid entry drives miss_o = 1 and hit_o = 0. pa_o then equals va_i zero-extended, and cachable_o is 0.
- R7: fill_i writes one entry from fill_va_i, fill_big_i, fill_ppn_i and fill_attr_i, where fill_attr_i = {C, W, X, U, G, D} (bit 5 down to bit 0). The entry can be looked up from the next cycle. The lowest-indexed invalid entry is chosen first.
- R8: When every entry is valid, a fill replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only after such a replacing fill.
- R9: ctx_flush_i invalidates every entry whose G bit is 0. Entries with G = 1 stay valid.
- R10: inval_i invalidates every valid entry that matches inval_va_i under that entry's page size. This applies to global entries as well.
- R11: acc_i encodes load = 0, store = 1, fetch = 2. On a hit, the fault code is chosen in this order of priority. A user access (user_i = 1) to a page with U = 0 gives code 3. Otherwise a store to a page with W = 0 gives code 1, and a fetch from a page with X = 0 gives code 2. fault_o is 1 exactly when the code is non-zero.
- R12: A store hit that passes the checks of R11 on a page with D = 0 gives code 4 (dirty update needed). With D = 1 it gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_wr_i | input | 1 | Write strobe for the enable state |
| en_val_i | input | 1 | Enable value written on en_wr_i |
| ctx_flush_i | input | 1 | Context-switch flush of non-global entries |
| inval_i | input | 1 | Single-address invalidate strobe |
| inval_va_i | input | 32 | Virtual address to invalidate |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Lookup virtual address |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| user_i | input | 1 | Access made in user mode |
| fill_i | input | 1 | Refill strobe |
| fill_va_i | input | 32 | Virtual address of the refilled page |
| fill_big_i | input | 1 | Refill is a 4 MB page |
| fill_attr_i | input | 6 | {C, W, X, U, G, D} of the refilled page |
| fill_ppn_i | input | 24 | Physical page number of the refilled page |
| hit_o | output | 1 | Lookup matched an entry |
| miss_o | output | 1 | Lookup found no entry; refill requested |
| pa_o | output | 36 | Physical address |
| cachable_o | output | 1 | C bit of the matching entry |
| fault_o | output | 1 | Access rights fault on a hit |
| fault_code_o | output | 3 | 0 none, 1 write, 2 execute, 3 user, 4 dirty |

## Verification
The bench looks up an address inside a 4 MB page, away from the base of the page. A design that compared 20 tag bits for large pages, or that took ppn[13:0] as the high part of the address, would report a miss or return the wrong address. After a flush it checks that the global 4 MB entry still hits and that the local entries miss. It then invalidates that global entry through an address with a different page offset, which catches an invalidate that skips global entries or compares the full address. It applies a user fetch and a store to the same page to separate the priority among codes 3, 1 and 2, and a store to a clean page to check code 4. It fills the buffer completely and then refills twice, checking which victims are evicted, so a pointer that moves on every fill or starts at the wrong place shows up. It also writes the enable state while a request is presented, to check the one-cycle delay before translation starts.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PPN_W     = 24;
  localparam int PA_W      = 36;
  localparam int SMALL_OFF = 12;
  localparam int BIG_OFF   = 22;
  localparam int TAG_W     = VA_W - SMALL_OFF;
  localparam int BIG_TAG_W = VA_W - BIG_OFF;
  localparam int BIG_PPN_W = PA_W - BIG_OFF;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_WRITE = 3'd1,
    FLT_EXEC  = 3'd2,
    FLT_USER  = 3'd3,
    FLT_DIRTY = 3'd4
  } flt_e;

  typedef struct packed {
    logic c;
    logic w;
    logic x;
    logic u;
    logic g;
    logic d;
  } attr_t;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             big;
    attr_t            attr;
    logic [PPN_W-1:0] ppn;
  } entry_t;
endpackage

// File: rtl/xlat_tlb_entry.sv
module xlat_tlb_entry
  import xlat_tlb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_we_i,
  input  entry_t          fill_data_i,
  input  logic            flush_i,
  input  logic            inval_i,
  input  logic [VA_W-1:0] inval_va_i,
  input  logic [VA_W-1:0] look_va_i,
  output logic            valid_o,
  output logic            look_hit_o,
  output logic            inval_hit_o,
  output entry_t          data_o
);
  logic   valid_q;
  entry_t data_q;

  function automatic logic tag_eq(input entry_t e, input logic [VA_W-1:0] va);
    if (e.big) return e.tag[TAG_W-1 -: BIG_TAG_W] == va[VA_W-1 -: BIG_TAG_W];
    else       return e.tag == va[VA_W-1 -: TAG_W];
  endfunction

  assign look_hit_o  = valid_q && tag_eq(data_q, look_va_i);
  assign inval_hit_o = valid_q && tag_eq(data_q, inval_va_i);
  assign valid_o     = valid_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (fill_we_i) begin
      valid_q <= 1'b1;
      data_q  <= fill_data_i;
    end else if ((flush_i && !data_q.attr.g) || (inval_i && inval_hit_o)) begin
      valid_q <= 1'b0;
    end
  end

  // flush leaves only global entries alive
  p_flush_drop_local_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !fill_we_i |=> !valid_q || data_q.attr.g);

  p_flush_keep_global_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !fill_we_i && !(inval_i && inval_hit_o) && valid_q && data_q.attr.g
    |=> valid_q);

  p_inval_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i && inval_hit_o && !fill_we_i |=> !valid_q);
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               fill_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_valid;

  assign all_valid = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_o = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && all_valid) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_free_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !all_valid |-> !valid_i[victim_o]);

  p_rr_only_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !all_valid |=> $stable(rr_q));
endmodule

// File: rtl/xlat_tlb_check.sv
module xlat_tlb_check
  import xlat_tlb_pkg::*;
(
  input  attr_t attr_i,
  input  acc_e  acc_i,
  input  logic  user_i,
  output flt_e  code_o
);
  always_comb begin
    code_o = FLT_NONE;
    if (user_i && !attr_i.u)                      code_o = FLT_USER;
    else if (acc_i == ACC_STORE && !attr_i.w)     code_o = FLT_WRITE;
    else if (acc_i == ACC_FETCH && !attr_i.x)     code_o = FLT_EXEC;
    else if (acc_i == ACC_STORE && !attr_i.d)     code_o = FLT_DIRTY;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_wr_i,
  input  logic        en_val_i,
  input  logic        ctx_flush_i,
  input  logic        inval_i,
  input  logic [31:0] inval_va_i,
  input  logic        req_i,
  input  logic [31:0] va_i,
  input  logic [1:0]  acc_i,
  input  logic        user_i,
  input  logic        fill_i,
  input  logic [31:0] fill_va_i,
  input  logic        fill_big_i,
  input  logic [5:0]  fill_attr_i,
  input  logic [23:0] fill_ppn_i,
  output logic        hit_o,
  output logic        miss_o,
  output logic [35:0] pa_o,
  output logic        cachable_o,
  output logic        fault_o,
  output logic [2:0]  fault_code_o
);
  logic               en_q;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] look_vec;
  logic [ENTRIES-1:0] inval_vec;
  entry_t             data_arr [ENTRIES];
  entry_t             fill_data;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   sel_idx;
  entry_t             sel_e;
  logic               any_hit;
  logic               xlat_hit;
  flt_e               chk_code;
  logic [PA_W-1:0]    pa_small;
  logic [PA_W-1:0]    pa_big;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_val_i;
  end

  assign fill_data.tag  = fill_va_i[VA_W-1 -: TAG_W];
  assign fill_data.big  = fill_big_i;
  assign fill_data.attr = attr_t'(fill_attr_i);
  assign fill_data.ppn  = fill_ppn_i;

  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_vec),
    .fill_i   (fill_i),
    .victim_o (victim_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_tlb_entry u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_we_i   (fill_i && (victim_idx == IDX_W'(g))),
      .fill_data_i (fill_data),
      .flush_i     (ctx_flush_i),
      .inval_i     (inval_i),
      .inval_va_i  (inval_va_i),
      .look_va_i   (va_i),
      .valid_o     (valid_vec[g]),
      .look_hit_o  (look_vec[g]),
      .inval_hit_o (inval_vec[g]),
      .data_o      (data_arr[g])
    );
  end

  // lowest matching index wins if duplicates were filled
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (look_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |look_vec;
  assign sel_e    = data_arr[sel_idx];
  assign xlat_hit = en_q && req_i && any_hit;

  xlat_tlb_check u_check (
    .attr_i (sel_e.attr),
    .acc_i  (acc_e'(acc_i)),
    .user_i (user_i),
    .code_o (chk_code)
  );

  assign pa_small = {sel_e.ppn, va_i[SMALL_OFF-1:0]};
  assign pa_big   = {sel_e.ppn[PPN_W-1 -: BIG_PPN_W], va_i[BIG_OFF-1:0]};

  always_comb begin
    hit_o        = xlat_hit;
    miss_o       = en_q && req_i && !any_hit;
    pa_o         = {{(PA_W-VA_W){1'b0}}, va_i};
    cachable_o   = 1'b0;
    fault_code_o = FLT_NONE;
    if (xlat_hit) begin
      pa_o         = sel_e.big ? pa_big : pa_small;
      cachable_o   = sel_e.attr.c;
      fault_code_o = chk_code;
    end
    fault_o = (fault_code_o != FLT_NONE);
  end

  p_hit_miss_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  p_fault_on_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o);

  p_off_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !hit_o && !miss_o && !fault_o && !cachable_o);

  p_fill_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_vec[$past(victim_idx)]);

  p_inval_gone_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i && !fill_i |=> (valid_vec & $past(inval_vec)) == '0);

  p_en_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && !en_val_i |=> !hit_o && !miss_o);
endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  localparam logic [2:0] OP_EN = 3'd0, OP_LOOK = 3'd1, OP_FILL = 3'd2,
                         OP_FLUSH = 3'd3, OP_INV = 3'd4;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
  localparam int NVEC = 20;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] va;
    logic [1:0]  kind;
    logic        usr;
    logic        big;
    logic [5:0]  attr;
    logic [23:0] ppn;
    logic [3:0]  rq;
    logic        e_hit;
    logic        e_miss;
    logic [2:0]  e_code;
    logic [35:0] e_pa;
    logic        e_c;
  } vec_t;

  // attr = {C,W,X,U,G,D}; EN op uses attr[0] as the enable value
  localparam vec_t VEC [NVEC] = '{
    '{OP_EN,    32'h0,        LD, 1'b0, 1'b0, 6'h01,      24'h0,      4'd2,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h00401234, LD, 1'b0, 1'b0, 6'h00,      24'h0,      4'd6,  1'b0, 1'b1, 3'd0, 36'h000401234, 1'b0},
    '{OP_FILL,  32'h00401000, LD, 1'b0, 1'b0, 6'b110101, 24'h0ABCDE, 4'd7,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h00401234, LD, 1'b1, 1'b0, 6'h00,      24'h0,      4'd4,  1'b1, 1'b0, 3'd0, 36'h0ABCDE234, 1'b1},
    '{OP_LOOK,  32'h00401234, ST, 1'b1, 1'b0, 6'h00,      24'h0,      4'd11, 1'b1, 1'b0, 3'd0, 36'h0ABCDE234, 1'b1},
    '{OP_LOOK,  32'h00401234, FE, 1'b0, 1'b0, 6'h00,      24'h0,      4'd11, 1'b1, 1'b0, 3'd2, 36'h0ABCDE234, 1'b1},
    '{OP_FILL,  32'h80400000, LD, 1'b0, 1'b1, 6'b001010, 24'h123456, 4'd5,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h80555678, FE, 1'b0, 1'b0, 6'h00,      24'h0,      4'd5,  1'b1, 1'b0, 3'd0, 36'h123555678, 1'b0},
    '{OP_LOOK,  32'h80555678, FE, 1'b1, 1'b0, 6'h00,      24'h0,      4'd11, 1'b1, 1'b0, 3'd3, 36'h123555678, 1'b0},
    '{OP_LOOK,  32'h80555678, ST, 1'b0, 1'b0, 6'h00,      24'h0,      4'd11, 1'b1, 1'b0, 3'd1, 36'h123555678, 1'b0},
    '{OP_FILL,  32'h00003000, LD, 1'b0, 1'b0, 6'b111100, 24'h000777, 4'd7,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h00003ABC, ST, 1'b1, 1'b0, 6'h00,      24'h0,      4'd12, 1'b1, 1'b0, 3'd4, 36'h000777ABC, 1'b1},
    '{OP_LOOK,  32'h00003ABC, LD, 1'b1, 1'b0, 6'h00,      24'h0,      4'd12, 1'b1, 1'b0, 3'd0, 36'h000777ABC, 1'b1},
    '{OP_FLUSH, 32'h0,        LD, 1'b0, 1'b0, 6'h00,      24'h0,      4'd9,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h00401234, LD, 1'b0, 1'b0, 6'h00,      24'h0,      4'd9,  1'b0, 1'b1, 3'd0, 36'h000401234, 1'b0},
    '{OP_LOOK,  32'h80555678, FE, 1'b0, 1'b0, 6'h00,      24'h0,      4'd9,  1'b1, 1'b0, 3'd0, 36'h123555678, 1'b0},
    '{OP_INV,   32'h80400ABC, LD, 1'b0, 1'b0, 6'h00,      24'h0,      4'd10, 1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h80555678, FE, 1'b0, 1'b0, 6'h00,      24'h0,      4'd10, 1'b0, 1'b1, 3'd0, 36'h080555678, 1'b0},
    '{OP_EN,    32'h0,        LD, 1'b0, 1'b0, 6'h00,      24'h0,      4'd2,  1'b0, 1'b0, 3'd0, 36'h0,         1'b0},
    '{OP_LOOK,  32'h80555678, FE, 1'b1, 1'b0, 6'h00,      24'h0,      4'd3,  1'b0, 1'b0, 3'd0, 36'h080555678, 1'b0}
  };
  // vector tags: R2 R3 R4 R5 R6 R7 R9 R10 R11 R12

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_wr_i, en_val_i, ctx_flush_i, inval_i, req_i, user_i, fill_i, fill_big_i;
  logic [31:0] inval_va_i, va_i, fill_va_i;
  logic [1:0]  acc_i;
  logic [5:0]  fill_attr_i;
  logic [23:0] fill_ppn_i;
  logic        hit_o, miss_o, cachable_o, fault_o;
  logic [35:0] pa_o;
  logic [2:0]  fault_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  xlat_tlb u_xlat_tlb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_wr_i(en_wr_i), .en_val_i(en_val_i),
    .ctx_flush_i(ctx_flush_i), .inval_i(inval_i), .inval_va_i(inval_va_i),
    .req_i(req_i), .va_i(va_i), .acc_i(acc_i), .user_i(user_i),
    .fill_i(fill_i), .fill_va_i(fill_va_i), .fill_big_i(fill_big_i),
    .fill_attr_i(fill_attr_i), .fill_ppn_i(fill_ppn_i),
    .hit_o(hit_o), .miss_o(miss_o), .pa_o(pa_o), .cachable_o(cachable_o),
    .fault_o(fault_o), .fault_code_o(fault_code_o)
  );

  task automatic idle();
    en_wr_i = 0; en_val_i = 0; ctx_flush_i = 0; inval_i = 0; inval_va_i = 0;
    req_i = 0; va_i = 0; acc_i = 0; user_i = 0;
    fill_i = 0; fill_va_i = 0; fill_big_i = 0; fill_attr_i = 0; fill_ppn_i = 0;
  endtask

  task automatic check(input string rq, input logic eh, input logic em,
                       input logic [2:0] ec, input logic [35:0] ep, input logic ecc);
    n_chk++;
    if (hit_o !== eh || miss_o !== em || fault_code_o !== ec || pa_o !== ep ||
        cachable_o !== ecc || fault_o !== (ec != 3'd0)) begin
      n_bad++;
      $display("FAIL %s va=%h: got hit=%b miss=%b code=%0d pa=%h c=%b flt=%b exp hit=%b miss=%b code=%0d pa=%h c=%b",
               rq, va_i, hit_o, miss_o, fault_code_o, pa_o, cachable_o, fault_o,
               eh, em, ec, ep, ecc);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k, input logic u);
    @(negedge clk_i); idle();
    req_i = 1; va_i = va; acc_i = k; user_i = u;
    #1;
  endtask

  task automatic fill(input logic [31:0] va, input logic [5:0] at, input logic [23:0] ppn);
    @(negedge clk_i); idle();
    fill_i = 1; fill_va_i = va; fill_attr_i = at; fill_ppn_i = ppn;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 / R3: after reset translation is off
    look(32'h12345678, LD, 1'b0);
    check("R1", 1'b0, 1'b0, 3'd0, 36'h012345678, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i); idle();
      case (VEC[i].op)
        OP_EN:    begin en_wr_i = 1; en_val_i = VEC[i].attr[0]; end
        OP_FILL:  begin fill_i = 1; fill_va_i = VEC[i].va; fill_big_i = VEC[i].big;
                        fill_attr_i = VEC[i].attr; fill_ppn_i = VEC[i].ppn; end
        OP_FLUSH: ctx_flush_i = 1;
        OP_INV:   begin inval_i = 1; inval_va_i = VEC[i].va; end
        default: begin
          req_i = 1; va_i = VEC[i].va; acc_i = VEC[i].kind; user_i = VEC[i].usr;
          #1;
          check($sformatf("R%0d", VEC[i].rq), VEC[i].e_hit, VEC[i].e_miss,
                VEC[i].e_code, VEC[i].e_pa, VEC[i].e_c);
        end
      endcase
    end

    // R2: enable write takes effect one cycle later
    @(negedge clk_i); idle();
    en_wr_i = 1; en_val_i = 1; req_i = 1; va_i = 32'h00001000;
    #1 check("R2", 1'b0, 1'b0, 3'd0, 36'h000001000, 1'b0);
    look(32'h00001000, LD, 1'b0);
    check("R2", 1'b0, 1'b1, 3'd0, 36'h000001000, 1'b0);

    // R8: fill all entries, then two replacing fills
    for (int i = 0; i < 8; i++) fill((32'h100 + i) << 12, 6'b111101, 24'(i));
    fill(32'h00200000, 6'b111101, 24'h0000AA);
    look(32'h00100000, LD, 1'b0);
    check("R8", 1'b0, 1'b1, 3'd0, 36'h000100000, 1'b0);
    look(32'h00101000, LD, 1'b0);
    check("R8", 1'b1, 1'b0, 3'd0, 36'h000001000, 1'b1);
    look(32'h00200123, LD, 1'b0);
    check("R8", 1'b1, 1'b0, 3'd0, 36'h0000AA123, 1'b1);
    fill(32'h00201000, 6'b111101, 24'h0000BB);
    look(32'h00101000, LD, 1'b0);
    check("R8", 1'b0, 1'b1, 3'd0, 36'h000101000, 1'b0);
    look(32'h00102000, LD, 1'b0);
    check("R8", 1'b1, 1'b0, 3'd0, 36'h000002000, 1'b1);

    // R1: a later reset clears enable and entries
    @(negedge clk_i); idle(); rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    look(32'h00200123, LD, 1'b0);
    check("R1", 1'b0, 1'b0, 3'd0, 36'h000200123, 1'b0);
    @(negedge clk_i); idle(); en_wr_i = 1; en_val_i = 1;
    look(32'h00200123, LD, 1'b0);
    check("R1", 1'b0, 1'b1, 3'd0, 36'h000200123, 1'b0);

    @(negedge clk_i); idle();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule